// File: doc/BRIEF.md
# Double-Buffered DAC Code Controller

This block keeps the digital state behind a single-channel voltage-output converter of 14 or 16 bits. A parallel command port carries already-decoded serial transactions. Codes written there go into a staging code register and reach the converter-facing DAC register only on a load. The load can be a combined write-and-load, a software load, or a strobe on an auxiliary input. Codes are held left-aligned in 16 bits. At 14 bits the two lowest bits always read zero.

The auxiliary input is active low and asynchronous to the clock. A configuration command sets its role. As a clear, a qualified low drives the DAC register to zero, midscale (0x8000) or full scale, and holds it there while the pin stays low. As a load strobe, a qualified low copies the code register into the DAC register once. The input passes through a two-flop synchronizer and a pulse-width filter. After a clear is released, `start_ok` stays low for a programmable removal interval, so an upstream serial decoder can defer a new transaction. A power-down selection is passed straight to the output termination switches. While it is set, the DAC register is frozen.

The auxiliary input is handled by a four-state machine:
- ST_IDLE: pin high.
- ST_FILTER: counting synchronized low samples.
- ST_ACTIVE: pulse qualified, waiting for release.
- ST_RECOVER: removal interval after a clear.

Its transitions are:
- idle→filter: first low sample.
- filter→idle: reject, the pin rose early.
- filter→active: qualify, the pin stayed low for `AUX_MIN_PW` samples.
- active→recover: release of a clear.
- active→idle: release of a load strobe.
- recover→idle: the interval has elapsed.

Top module: `dac_dbuf_ctrl`

## Requirements
- R1: Command op 0 (write) stores `cmd_data` in the code register and leaves `dac_code` unchanged.
- R2: After reset the outputs are as follows:
  - `dac_code` is 0.
  - `pd_sel` is 0.
  - `start_ok` is 1.
  - The auxiliary role is clear, with clear value zero.
- R3: Command op 1 (write and load) stores the code and shows it on `dac_code` one clock later.
- R4: Command op 2 (load) copies the code register to `dac_code` one clock later.
- R5: Codes are left-aligned. With `RES_BITS`=14, bits 1:0 of every stored code are 0.
- R6: Command op 3 (configure) takes its fields from `cmd_data`:
  - Bit 0 selects the auxiliary role: 0 is clear, 1 is load.
  - Bits 2:1 select the clear value: 00 zero, 01 midscale 0x8000, 10 full scale, 11 zero.
  - Bits 4:3 set the power-down mode, which appears on `pd_sel`: 00 normal, 01 1k to ground, 10 100k to ground, 11 high impedance.
- R7: An auxiliary low lasting at least `AUX_MIN_PW` clocks acts. A shorter low has no effect.
- R8: In clear role, a qualified low drives `dac_code` to the clear value and holds it until release. Writes during the hold update only the code register.
- R9: In load role, a qualified low copies the code register to `dac_code` once.
- R10: `start_ok` is low while a clear is held, and for `CLR_REMOVAL` to `CLR_REMOVAL`+3 clocks after release.
- R11: While `pd_sel` is nonzero, `dac_code` does not change. On return to normal it shows the value held before power-down, and loads can then reach the code written meanwhile.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe, one command per cycle |
| cmd_op | input | 2 | 0 write, 1 write and load, 2 load, 3 configure |
| cmd_data | input | 16 | Left-aligned code or configuration fields |
| aux_n | input | 1 | Asynchronous active-low clear/load pin |
| dac_code | output | 16 | DAC register, left-aligned |
| pd_sel | output | 2 | Power-down termination select |
| start_ok | output | 1 | High when a new serial transaction may start |

## Verification
The code register is visible only through a later load. A corrupted staging value therefore shows on `dac_code` one clock after the next op 1 or op 2, or after a load strobe. A filter or state-machine fault shows in three ways. A pulse one clock short of the limit might change `dac_code`. A qualified clear might fail to reach the clear value within `AUX_MIN_PW`+3 clocks. Or `start_ok` might rise outside its window after release. Frozen-register faults under power-down show on the first load issued while `pd_sel` is nonzero, and on the value seen when normal mode returns.

// File: rtl/dac_dbuf_pkg.sv
package dac_dbuf_pkg;

    typedef enum logic [1:0] {
        OP_WRITE      = 2'd0,
        OP_WRITE_LOAD = 2'd1,
        OP_LOAD       = 2'd2,
        OP_CONFIG     = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        PD_ON   = 2'd0,
        PD_1K   = 2'd1,
        PD_100K = 2'd2,
        PD_HIZ  = 2'd3
    } pd_e;

    typedef enum logic [1:0] {
        CLR_ZERO  = 2'd0,
        CLR_MID   = 2'd1,
        CLR_FULL  = 2'd2,
        CLR_ZERO2 = 2'd3
    } clr_e;

    function automatic logic [15:0] clear_code(input clr_e sel, input logic [15:0] mask);
        unique case (sel)
            CLR_MID:  clear_code = 16'h8000;
            CLR_FULL: clear_code = mask;
            default:  clear_code = 16'h0000;
        endcase
    endfunction

endpackage

// File: rtl/dac_aux_fsm.sv
module dac_aux_fsm
    import dac_dbuf_pkg::*;
#(
    parameter int MIN_PW  = 4,
    parameter int REMOVAL = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic aux_n,
    input  logic mode_load,
    output logic fire_clr,
    output logic fire_load,
    output logic clr_hold,
    output logic start_ok
);
    localparam int CMAX = (MIN_PW > REMOVAL) ? MIN_PW : REMOVAL;
    localparam int CW   = $clog2(CMAX + 1);

    typedef enum logic [1:0] {ST_IDLE, ST_FILTER, ST_ACTIVE, ST_RECOVER} st_e;

    st_e           state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          sync1_q, aux_s2;
    logic          kind_clr_q;
    logic          qualify;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync1_q <= 1'b1;
            aux_s2  <= 1'b1;
        end else begin
            sync1_q <= aux_n;
            aux_s2  <= sync1_q;
        end
    end

    assign qualify = (state_q == ST_FILTER) && !aux_s2 && (cnt_q == CW'(MIN_PW - 1));

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: if (!aux_s2) begin
                state_d = ST_FILTER;
                cnt_d   = CW'(1);
            end
            ST_FILTER: begin
                if (aux_s2)       state_d = ST_IDLE;
                else if (qualify) state_d = ST_ACTIVE;
                else              cnt_d   = cnt_q + CW'(1);
            end
            ST_ACTIVE: if (aux_s2) begin
                if (kind_clr_q) begin
                    state_d = ST_RECOVER;
                    cnt_d   = '0;
                end else begin
                    state_d = ST_IDLE;
                end
            end
            ST_RECOVER: begin
                if (cnt_q == CW'(REMOVAL - 1)) state_d = ST_IDLE;
                else                           cnt_d   = cnt_q + CW'(1);
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            cnt_q      <= '0;
            kind_clr_q <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            if (qualify) kind_clr_q <= !mode_load;
        end
    end

    always_comb begin
        fire_clr  = qualify && !mode_load;
        fire_load = qualify && mode_load;
        clr_hold  = (state_q == ST_ACTIVE) && kind_clr_q;
        start_ok  = !(clr_hold || (state_q == ST_RECOVER));
    end

    a_r7_fire_after_low: assert property (@(posedge clk) disable iff (!rst_n)
        (fire_clr || fire_load) |-> (!aux_s2 && $past(!aux_s2)));

    a_r10_recover_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RECOVER && cnt_q != CW'(REMOVAL - 1)) |=> !start_ok);

endmodule

// File: rtl/dac_regs.sv
module dac_regs
    import dac_dbuf_pkg::*;
#(
    parameter int RES_BITS = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_valid,
    input  logic [1:0]  cmd_op,
    input  logic [15:0] cmd_data,
    input  logic        fire_clr,
    input  logic        fire_load,
    input  logic        clr_hold,
    output logic [15:0] dac_q,
    output logic [1:0]  pd_out,
    output logic        mode_load
);
    localparam logic [15:0] CODE_MASK = ~((16'd1 << (16 - RES_BITS)) - 16'd1);

    op_e         op;
    pd_e         pd_q;
    clr_e        sel_q;
    logic        load_mode_q;
    logic [15:0] code_q, dac_d, wr_code, clr_val;

    assign op        = op_e'(cmd_op);
    assign wr_code   = cmd_data & CODE_MASK;
    assign clr_val   = clear_code(sel_q, CODE_MASK);
    assign pd_out    = pd_q;
    assign mode_load = load_mode_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            code_q      <= '0;
            pd_q        <= PD_ON;
            sel_q       <= CLR_ZERO;
            load_mode_q <= 1'b0;
        end else if (cmd_valid) begin
            if (op == OP_WRITE || op == OP_WRITE_LOAD) code_q <= wr_code;
            if (op == OP_CONFIG) begin
                load_mode_q <= cmd_data[0];
                sel_q       <= clr_e'(cmd_data[2:1]);
                pd_q        <= pd_e'(cmd_data[4:3]);
            end
        end
    end

    always_comb begin
        dac_d = dac_q;
        if (pd_q != PD_ON)                                dac_d = dac_q;
        else if (fire_clr || clr_hold)                    dac_d = clr_val;
        else if (fire_load)                               dac_d = code_q;
        else if (cmd_valid && op == OP_WRITE_LOAD)        dac_d = wr_code;
        else if (cmd_valid && op == OP_LOAD)              dac_d = code_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) dac_q <= '0;
        else        dac_q <= dac_d;
    end

    a_r11_pd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_q != PD_ON) |=> $stable(dac_q));

    a_r8_clear_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_hold && pd_q == PD_ON) |=> (dac_q == $past(clr_val)));

    a_r5_code_mask: assert property (@(posedge clk) disable iff (!rst_n)
        ((dac_q & ~CODE_MASK) == 16'd0) && ((code_q & ~CODE_MASK) == 16'd0));

endmodule

// File: rtl/dac_dbuf_ctrl.sv
module dac_dbuf_ctrl
    import dac_dbuf_pkg::*;
#(
    parameter int RES_BITS        = 16,
    parameter int AUX_MIN_PW      = 4,
    parameter int CLR_REMOVAL_CYC = 20
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_valid,
    input  logic [1:0]  cmd_op,
    input  logic [15:0] cmd_data,
    input  logic        aux_n,
    output logic [15:0] dac_code,
    output logic [1:0]  pd_sel,
    output logic        start_ok
);
    logic fire_clr, fire_load, clr_hold, mode_load;

    dac_aux_fsm #(
        .MIN_PW (AUX_MIN_PW),
        .REMOVAL(CLR_REMOVAL_CYC)
    ) u_aux (
        .clk      (clk),
        .rst_n    (rst_n),
        .aux_n    (aux_n),
        .mode_load(mode_load),
        .fire_clr (fire_clr),
        .fire_load(fire_load),
        .clr_hold (clr_hold),
        .start_ok (start_ok)
    );

    dac_regs #(
        .RES_BITS(RES_BITS)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_valid(cmd_valid),
        .cmd_op   (cmd_op),
        .cmd_data (cmd_data),
        .fire_clr (fire_clr),
        .fire_load(fire_load),
        .clr_hold (clr_hold),
        .dac_q    (dac_code),
        .pd_out   (pd_sel),
        .mode_load(mode_load)
    );

    a_r1_write_only_no_dac: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == OP_WRITE && !fire_clr && !fire_load && !clr_hold)
        |=> $stable(dac_code));

endmodule

// File: tb/dac_dbuf_ctrl_bench.sv
module dac_dbuf_ctrl_bench;
    localparam int MIN_PW = 4;
    localparam int REM    = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = 2'd0;
    logic [15:0] cmd_data = 16'd0;
    logic        aux_n = 1'b1;
    logic [15:0] dac16, dac14;
    logic [1:0]  pd16, pd14;
    logic        ok16, ok14;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [15:0] m_code16 = 16'd0, m_code14 = 16'd0, m_dac16 = 16'd0, m_dac14 = 16'd0;
    logic [1:0]  m_pd = 2'd0;

    always #2.5 clk = ~clk;

    dac_dbuf_ctrl #(.RES_BITS(16), .AUX_MIN_PW(MIN_PW), .CLR_REMOVAL_CYC(REM)) u_dac_dbuf_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_data(cmd_data),
        .aux_n(aux_n), .dac_code(dac16), .pd_sel(pd16), .start_ok(ok16));

    dac_dbuf_ctrl #(.RES_BITS(14), .AUX_MIN_PW(MIN_PW), .CLR_REMOVAL_CYC(REM)) u_dac_dbuf_ctrl_r14 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_data(cmd_data),
        .aux_n(aux_n), .dac_code(dac14), .pd_sel(pd14), .start_ok(ok14));

    function automatic logic [15:0] mask14(input logic [15:0] d);
        return d & 16'hFFFC;
    endfunction

    task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic model(input logic [1:0] op, input logic [15:0] d);
        if (op == 2'd0 || op == 2'd1) begin
            m_code16 = d;
            m_code14 = mask14(d);
        end
        if (m_pd == 2'd0 && (op == 2'd1 || op == 2'd2)) begin
            m_dac16 = m_code16;
            m_dac14 = m_code14;
        end
        if (op == 2'd3) m_pd = d[4:3];
    endtask

    task automatic cmd(input logic [1:0] op, input logic [15:0] d);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op    = op;
        cmd_data  = d;
        model(op, d);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic chk_dac(input string tag);
        chk({tag, " dac16"}, dac16, m_dac16);
        chk({tag, " dac14"}, dac14, m_dac14);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired got=hung exp=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int lowcnt;
        bit seen_high;
        void'($urandom(32'd24680));
        idle(3);
        rst_n = 1'b1;
        idle(2);

        // R2 reset state
        chk("R2 dac16", dac16, 16'h0000);
        chk("R2 dac14", dac14, 16'h0000);
        chk("R2 pd", {14'd0, pd16}, 16'd0);
        chk("R2 start_ok", {15'd0, ok16}, 16'd1);

        // R1 write only, then R4 load, R5 masking
        cmd(2'd0, 16'h1237);
        chk_dac("R1 write-only");
        chk("R1 dac unchanged", dac16, 16'h0000);
        cmd(2'd2, 16'h0000);
        chk("R4 load16", dac16, 16'h1237);
        chk("R5 load14 masked", dac14, 16'h1234);

        // R3 write and load
        cmd(2'd1, 16'hABCD);
        chk("R3 wl16", dac16, 16'hABCD);
        chk("R5 wl14", dac14, 16'hABCC);

        // random mix (R1 R3 R4 R6 R11)
        for (int i = 0; i < 300; i++) begin
            logic [1:0]  op;
            logic [15:0] d;
            op = 2'($urandom_range(0, 3));
            d  = 16'($urandom);
            if (op == 2'd3) d = {11'd0, d[4:0]};
            cmd(op, d);
            chk_dac("R4 random");
            chk("R6 random pd", {14'd0, pd14}, {14'd0, m_pd});
        end
        cmd(2'd3, 16'h0000);
        chk("R6 pd back to normal", {14'd0, pd16}, 16'd0);

        // R11 power-down freeze and restore
        cmd(2'd1, 16'h4000);
        cmd(2'd3, 16'h0008);
        chk("R6 pd 1k", {14'd0, pd16}, 16'd1);
        cmd(2'd1, 16'h7777);
        chk("R11 wl frozen", dac16, 16'h4000);
        cmd(2'd2, 16'h0000);
        chk("R11 load frozen", dac16, 16'h4000);
        cmd(2'd3, 16'h0018);
        chk("R6 pd hiz", {14'd0, pd16}, 16'd3);
        cmd(2'd3, 16'h0000);
        chk("R11 restored", dac16, 16'h4000);
        cmd(2'd2, 16'h0000);
        chk("R11 later load16", dac16, 16'h7777);
        chk("R11 later load14", dac14, 16'h7774);

        // R7 short pulse rejected, clear role midscale
        cmd(2'd3, 16'h0002);
        cmd(2'd1, 16'h1111);
        @(negedge clk); aux_n = 1'b0;
        idle(MIN_PW - 1);
        aux_n = 1'b1;
        idle(MIN_PW + 6);
        chk("R7 short pulse ignored", dac16, 16'h1111);
        chk("R7 short pulse start_ok", {15'd0, ok16}, 16'd1);

        // R8 long clear, held, writes go to code register
        aux_n = 1'b0;
        idle(MIN_PW + 4);
        chk("R8 clear mid16", dac16, 16'h8000);
        chk("R8 clear mid14", dac14, 16'h8000);
        chk("R10 blocked while held", {15'd0, ok16}, 16'd0);
        cmd(2'd1, 16'h2222);
        chk("R8 held during write", dac16, 16'h8000);
        idle(3);
        chk("R8 still held", dac14, 16'h8000);
        aux_n = 1'b1;
        lowcnt = 0;
        seen_high = 1'b0;
        for (int k = 0; k < REM + 20; k++) begin
            @(negedge clk);
            if (!seen_high) begin
                if (!ok16) lowcnt++;
                else seen_high = 1'b1;
            end
        end
        checks++;
        if (!(lowcnt >= REM && lowcnt <= REM + 3)) begin
            failures++;
            $display("FAIL R10 removal window got=%0d exp=%0d..%0d", lowcnt, REM, REM + 3);
        end
        chk("R8 value after release", dac16, 16'h8000);
        cmd(2'd2, 16'h0000);
        chk("R8 written code16", dac16, 16'h2222);
        chk("R8 written code14", dac14, 16'h2220);

        // R8 full scale clear
        cmd(2'd3, 16'h0004);
        @(negedge clk); aux_n = 1'b0;
        idle(MIN_PW + 2);
        aux_n = 1'b1;
        idle(4);
        chk("R8 full16", dac16, 16'hFFFF);
        chk("R8 full14", dac14, 16'hFFFC);
        idle(REM + 6);

        // R7 boundary: exactly MIN_PW cycles qualifies, clear to zero
        cmd(2'd3, 16'h0000);
        @(negedge clk); aux_n = 1'b0;
        idle(MIN_PW);
        aux_n = 1'b1;
        idle(4);
        chk("R7 exact width fires", dac16, 16'h0000);
        idle(REM + 6);

        // R9 load role
        cmd(2'd3, 16'h0001);
        cmd(2'd0, 16'h5A5A);
        chk("R1 no dac before strobe", dac16, 16'h0000);
        @(negedge clk); aux_n = 1'b0;
        idle(MIN_PW + 4);
        chk("R9 strobe load16", dac16, 16'h5A5A);
        chk("R9 strobe load14", dac14, 16'h5A58);
        chk("R10 load role start_ok", {15'd0, ok16}, 16'd1);
        cmd(2'd0, 16'h0F0F);
        idle(2);
        chk("R9 single copy", dac16, 16'h5A5A);
        aux_n = 1'b1;
        idle(4);
        chk("R10 load release start_ok", {15'd0, ok16}, 16'd1);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule